// File: doc/BRIEF.md
# Dual 8-bit timer register front end

This block sits between a simple request/response register bus and the counting core of a two-channel 8-bit timer. It decodes a 4-bit byte address into a channel and one of six per-channel registers. It holds the mode, status, two compare and clock-select registers for both channels, and drives their stored values to the counter core.

Accesses are byte wide or halfword wide. A halfword access reaches the same register in both channels at once, with channel 0 in the upper byte and channel 1 in the lower byte. Halfword accesses to odd addresses, or to the mode or status registers, are rejected. Rejected and unmapped reads return all ones, and the matching writes are dropped.

Counter reads are taken from the core's live count. Counter writes are handed to the core as per-channel write strobes. Any write that changes a value the core uses also raises a one-cycle update strobe for each channel it touches.

Top module: `dtmr_busif`

## Requirements
- R1: Address bit 0 selects the channel, and bits 3:1 select the register: 0 mode, 1 status, 2 compare A, 3 compare B, 4 count, 5 clock select. A legal byte write stores wdata_i[7:0] in the addressed register. A byte read returns the register's view in rdata_o[7:0] with rdata_o[15:8] zero. The read data and rvalid_o appear in the cycle after the request.
- R2: A legal halfword access places channel 0 in bits 15:8 and channel 1 in bits 7:0, for both reads and writes.
- R3: A halfword access is illegal when the address is odd or the register code is 0 or 1. An illegal read returns 16'hFFFF. An illegal write changes no register and raises no strobe.
- R4: Register codes 6 and 7 (offsets 12 to 15) are unmapped. Their reads return 16'hFFFF, and writes to them change nothing and raise no strobe.
- R5: A mode register read returns the stored bits 7:3, with bits 2:0 reading as zero.
- R6: A clock-select register read returns the stored bits 7 and 4:0, with bits 6:5 reading as zero.
- R7: Channel 1's status register reads with bits 5:4 forced to 01, whatever was written. Channel 0's status register reads back all written bits.
- R8: After reset, both compare registers of both channels hold 8'hFF, channel 1's status register holds 8'h10, and all other registers hold zero.
- R9: A count read returns the byte(s) of cnt_i present in the request cycle, with cnt_i packed in the same way as R2. A legal count write sets cnt_we_o bit c for each written channel c in the next cycle, and places the data in that channel's lane of cnt_wdata_o. No count value is stored in this block.
- R10: In the cycle after a legal write to compare A, compare B, count or clock select, upd_o bit c pulses for exactly one cycle for each written channel c. Mode and status writes raise no update strobe.
- R11: The outputs mode_o, stat_o, cmpa_o, cmpb_o and clksel_o carry the full stored bytes, packed as in R2. They change in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = halfword access, 0 = byte access |
| addr_i | input | 4 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| cnt_i | input | 16 | Live counts from the core, channel 0 high |
| cnt_we_o | output | 2 | Count write strobe per channel, bit index = channel |
| cnt_wdata_o | output | 16 | Count write data, channel 0 high |
| upd_o | output | 2 | Update strobe per channel, bit index = channel |
| mode_o | output | 16 | Stored mode registers, channel 0 high |
| stat_o | output | 16 | Stored status registers, channel 0 high |
| cmpa_o | output | 16 | Compare A registers, channel 0 high |
| cmpb_o | output | 16 | Compare B registers, channel 0 high |
| clksel_o | output | 16 | Clock-select registers, channel 0 high |

## Verification
Every result of this block is due exactly one clock edge after the request is sampled. The edge loads read data and rvalid_o, the count and update strobes, and the stored register outputs together. The bench applies each request at a falling edge and drops it at the next falling edge. At that same point it samples the response, the strobes and the configuration outputs, half a period after the edge that produced them. One further falling edge later it confirms that the strobes have returned to zero, which shows they last a single cycle.

// File: rtl/dtmr_pkg.sv
`timescale 1ns/1ps
package dtmr_pkg;
    localparam int NCH = 2;
    localparam int BW  = 8;
    localparam int WW  = NCH * BW;
    localparam int AW  = 4;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_CMPA  = 3'd2,
        SEL_CMPB  = 3'd3,
        SEL_COUNT = 3'd4,
        SEL_CLK   = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } sel_e;

    typedef struct packed {
        logic legal;
        logic wide;
        logic ch;
        sel_e sel;
    } acc_t;

    localparam logic [BW-1:0] MODE_RMASK = 8'hF8;
    localparam logic [BW-1:0] CLK_RMASK  = 8'h9F;
    localparam logic [BW-1:0] CMP_RST    = 8'hFF;
    localparam logic [BW-1:0] STAT1_RST  = 8'h10;

    // bit offset of a channel's lane inside a packed word: channel 0 highest
    function automatic int lane(int c);
        return (NCH - 1 - c) * BW;
    endfunction

    // status view: channel 1 has a hard-wired 01 at bits 5:4
    function automatic logic [BW-1:0] stat_view(logic is_ch1, logic [BW-1:0] raw);
        return is_ch1 ? {raw[7:6], 2'b01, raw[3:0]} : raw;
    endfunction

    function automatic logic hits_core(sel_e s);
        return (s == SEL_CMPA) || (s == SEL_CMPB) || (s == SEL_COUNT) || (s == SEL_CLK);
    endfunction
endpackage

// File: rtl/dtmr_dec.sv
`timescale 1ns/1ps
module dtmr_dec
    import dtmr_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wide,
    output acc_t          acc
);
    sel_e sel;
    logic mapped;
    logic wide_bad;

    always_comb begin
        sel      = sel_e'(addr[3:1]);
        mapped   = !((sel == SEL_RSV6) || (sel == SEL_RSV7));
        wide_bad = wide && (addr[0] || (sel == SEL_MODE) || (sel == SEL_STAT));
        acc.sel   = sel;
        acc.ch    = addr[0];
        acc.wide  = wide;
        acc.legal = mapped && !wide_bad;
    end
endmodule

// File: rtl/dtmr_regs.sv
`timescale 1ns/1ps
module dtmr_regs
    import dtmr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCH-1:0]         wr_en,
    input  sel_e                   sel,
    input  logic [NCH-1:0][BW-1:0] wbyte,
    output logic [NCH-1:0][BW-1:0] mode_q,
    output logic [NCH-1:0][BW-1:0] stat_q,
    output logic [NCH-1:0][BW-1:0] cmpa_q,
    output logic [NCH-1:0][BW-1:0] cmpb_q,
    output logic [NCH-1:0][BW-1:0] clk_q
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [BW-1:0] STAT_RST = (c == 1) ? STAT1_RST : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q[c] <= '0;
                stat_q[c] <= STAT_RST;
                cmpa_q[c] <= CMP_RST;
                cmpb_q[c] <= CMP_RST;
                clk_q[c]  <= '0;
            end else if (wr_en[c]) begin
                case (sel)
                    SEL_MODE: mode_q[c] <= wbyte[c];
                    SEL_STAT: stat_q[c] <= wbyte[c];
                    SEL_CMPA: cmpa_q[c] <= wbyte[c];
                    SEL_CMPB: cmpb_q[c] <= wbyte[c];
                    SEL_CLK:  clk_q[c]  <= wbyte[c];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dtmr_rdmux.sv
`timescale 1ns/1ps
module dtmr_rdmux
    import dtmr_pkg::*;
(
    input  acc_t                   acc,
    input  logic [NCH-1:0][BW-1:0] mode_q,
    input  logic [NCH-1:0][BW-1:0] stat_q,
    input  logic [NCH-1:0][BW-1:0] cmpa_q,
    input  logic [NCH-1:0][BW-1:0] cmpb_q,
    input  logic [NCH-1:0][BW-1:0] clk_q,
    input  logic [NCH-1:0][BW-1:0] cnt_q,
    output logic [WW-1:0]          rdata
);
    logic [NCH-1:0][BW-1:0] view;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            case (acc.sel)
                SEL_MODE:  view[c] = mode_q[c] & MODE_RMASK;
                SEL_STAT:  view[c] = stat_view(c == 1, stat_q[c]);
                SEL_CMPA:  view[c] = cmpa_q[c];
                SEL_CMPB:  view[c] = cmpb_q[c];
                SEL_COUNT: view[c] = cnt_q[c];
                SEL_CLK:   view[c] = clk_q[c] & CLK_RMASK;
                default:   view[c] = '1;
            endcase
        end

        rdata = '0;
        if (!acc.legal) begin
            rdata = '1;
        end else if (acc.wide) begin
            for (int c = 0; c < NCH; c++) begin
                rdata[lane(c) +: BW] = view[c];
            end
        end else begin
            rdata[BW-1:0] = view[acc.ch];
        end
    end
endmodule

// File: rtl/dtmr_busif.sv
`timescale 1ns/1ps
module dtmr_busif
    import dtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          we_i,
    input  logic          wide_i,
    input  logic [AW-1:0] addr_i,
    input  logic [WW-1:0] wdata_i,
    output logic [WW-1:0] rdata_o,
    output logic          rvalid_o,
    input  logic [WW-1:0] cnt_i,
    output logic [NCH-1:0] cnt_we_o,
    output logic [WW-1:0] cnt_wdata_o,
    output logic [NCH-1:0] upd_o,
    output logic [WW-1:0] mode_o,
    output logic [WW-1:0] stat_o,
    output logic [WW-1:0] cmpa_o,
    output logic [WW-1:0] cmpb_o,
    output logic [WW-1:0] clksel_o
);
    acc_t                   acc;
    logic                   wr_ok;
    logic                   rd_req;
    logic [NCH-1:0]         wr_en;
    logic [NCH-1:0][BW-1:0] wbyte;
    logic [NCH-1:0][BW-1:0] mode_q, stat_q, cmpa_q, cmpb_q, clk_q, cnt_q;
    logic [WW-1:0]          rd_n;
    logic [WW-1:0]          wflat;

    dtmr_dec u_dec (
        .addr (addr_i),
        .wide (wide_i),
        .acc  (acc)
    );

    assign wr_ok  = req_i && we_i && acc.legal;
    assign rd_req = req_i && !we_i;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign wr_en[c]  = wr_ok && (acc.wide || (int'(acc.ch) == c));
        assign wbyte[c]  = acc.wide ? wdata_i[lane(c) +: BW] : wdata_i[BW-1:0];
        assign wflat[lane(c) +: BW]    = wbyte[c];
        assign cnt_q[c]                = cnt_i[lane(c) +: BW];
        assign mode_o[lane(c) +: BW]   = mode_q[c];
        assign stat_o[lane(c) +: BW]   = stat_q[c];
        assign cmpa_o[lane(c) +: BW]   = cmpa_q[c];
        assign cmpb_o[lane(c) +: BW]   = cmpb_q[c];
        assign clksel_o[lane(c) +: BW] = clk_q[c];
    end

    dtmr_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (acc.sel),
        .wbyte  (wbyte),
        .mode_q (mode_q),
        .stat_q (stat_q),
        .cmpa_q (cmpa_q),
        .cmpb_q (cmpb_q),
        .clk_q  (clk_q)
    );

    dtmr_rdmux u_rdmux (
        .acc    (acc),
        .mode_q (mode_q),
        .stat_q (stat_q),
        .cmpa_q (cmpa_q),
        .cmpb_q (cmpb_q),
        .clk_q  (clk_q),
        .cnt_q  (cnt_q),
        .rdata  (rd_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o     <= '0;
            rvalid_o    <= 1'b0;
            cnt_we_o    <= '0;
            cnt_wdata_o <= '0;
            upd_o       <= '0;
        end else begin
            rvalid_o    <= rd_req;
            if (rd_req) rdata_o <= rd_n;
            cnt_we_o    <= (acc.sel == SEL_COUNT) ? wr_en : '0;
            upd_o       <= hits_core(acc.sel) ? wr_en : '0;
            cnt_wdata_o <= wflat;
        end
    end

    // rejected halfword reads answer all ones
    assert_bad_wide_read_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && acc.wide && !acc.legal) |=> (rdata_o == '1 && rvalid_o));

    // rejected or unmapped writes leave every register and strobe untouched
    assert_dropped_write_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i && we_i && !acc.legal) |=> ($stable(mode_o) && $stable(stat_o) &&
            $stable(cmpa_o) && $stable(cmpb_o) && $stable(clksel_o) &&
            upd_o == '0 && cnt_we_o == '0));

    assert_unmapped_read_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (addr_i[3:1] == 3'd6 || addr_i[3:1] == 3'd7)) |=> (rdata_o == '1));

    assert_mode_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && acc.legal && acc.sel == SEL_MODE) |=> (rdata_o[2:0] == 3'b000));

    assert_clk_gap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && acc.legal && !acc.wide && acc.sel == SEL_CLK) |=> (rdata_o[6:5] == 2'b00));

    assert_stat1_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && acc.legal && !acc.wide && acc.ch && acc.sel == SEL_STAT)
            |=> (rdata_o[5:4] == 2'b01));

    assert_idle_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(req_i && we_i) |=> (upd_o == '0 && cnt_we_o == '0));

    assert_byte_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (req_i && we_i && !wide_i) |=> ($onehot0(upd_o) && $onehot0(cnt_we_o)));
endmodule

// File: tb/dtmr_busif_tb_top.sv
`timescale 1ns/1ps
module dtmr_busif_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_i, we_i, wide_i;
    logic [3:0]  addr_i;
    logic [15:0] wdata_i, rdata_o, cnt_i, cnt_wdata_o;
    logic [15:0] mode_o, stat_o, cmpa_o, cmpb_o, clksel_o;
    logic        rvalid_o;
    logic [1:0]  cnt_we_o, upd_o;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dtmr_busif dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i), .wide_i(wide_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .cnt_i(cnt_i), .cnt_we_o(cnt_we_o), .cnt_wdata_o(cnt_wdata_o), .upd_o(upd_o),
        .mode_o(mode_o), .stat_o(stat_o), .cmpa_o(cmpa_o), .cmpb_o(cmpb_o),
        .clksel_o(clksel_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; results sampled at the falling edge after the capturing edge
    task automatic xfer(input logic we, input logic wide, input logic [3:0] a,
                        input logic [15:0] d, output logic [15:0] rd,
                        output logic [1:0] up, output logic [1:0] cw);
        @(negedge clk);
        req_i = 1'b1; we_i = we; wide_i = wide; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        rd = rdata_o; up = upd_o; cw = cnt_we_o;
    endtask

    task automatic t_reset;
        logic [15:0] rd; logic [1:0] up, cw;
        check("R8 cmpa", cmpa_o, 16'hFFFF);
        check("R8 cmpb", cmpb_o, 16'hFFFF);
        check("R8 stat", stat_o, 16'h0010);
        check("R8 mode", mode_o, 16'h0000);
        check("R8 clksel", clksel_o, 16'h0000);
        xfer(1'b0, 1'b0, 4'd3, 16'h0, rd, up, cw);
        check("R8 stat ch1 read", rd, 16'h0010);
        check("R1 rvalid", {15'd0, rvalid_o}, 16'h0001);
        xfer(1'b0, 1'b1, 4'd4, 16'h0, rd, up, cw);
        check("R8 cmpa wide read", rd, 16'hFFFF);
    endtask

    task automatic t_mode;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b0, 4'd1, 16'h00A8, rd, up, cw);
        check("R11 mode out", mode_o, 16'h00A8);
        check("R10 mode no strobe", {14'd0, up}, 16'h0000);
        xfer(1'b0, 1'b0, 4'd1, 16'h0, rd, up, cw);
        check("R1 mode ch1 read", rd, 16'h00A8);
        xfer(1'b1, 1'b0, 4'd0, 16'h00FF, rd, up, cw);
        check("R11 mode raw", mode_o, 16'hFFA8);
        xfer(1'b0, 1'b0, 4'd0, 16'h0, rd, up, cw);
        check("R5 mode mask", rd, 16'h00F8);
    endtask

    task automatic t_clk;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b0, 4'd10, 16'h00FF, rd, up, cw);
        check("R10 clk ch0 strobe", {14'd0, up}, 16'h0001);
        xfer(1'b0, 1'b0, 4'd10, 16'h0, rd, up, cw);
        check("R6 clk mask", rd, 16'h009F);
        xfer(1'b1, 1'b1, 4'd10, 16'h1234, rd, up, cw);
        check("R2 clk wide write", clksel_o, 16'h1234);
        xfer(1'b0, 1'b1, 4'd10, 16'h0, rd, up, cw);
        check("R6 clk wide read", rd, 16'h1214);
    endtask

    task automatic t_pack;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b1, 4'd4, 16'hBEEF, rd, up, cw);
        check("R10 wide strobe", {14'd0, up}, 16'h0003);
        check("R2 cmpa out", cmpa_o, 16'hBEEF);
        xfer(1'b0, 1'b0, 4'd4, 16'h0, rd, up, cw);
        check("R2 ch0 byte", rd, 16'h00BE);
        xfer(1'b0, 1'b0, 4'd5, 16'h0, rd, up, cw);
        check("R2 ch1 byte", rd, 16'h00EF);
        xfer(1'b0, 1'b1, 4'd4, 16'h0, rd, up, cw);
        check("R2 wide read", rd, 16'hBEEF);
    endtask

    task automatic t_illegal;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b1, 4'd7, 16'h1111, rd, up, cw);
        check("R3 odd write ignored", cmpb_o, 16'hFFFF);
        check("R3 odd write no strobe", {14'd0, up}, 16'h0000);
        xfer(1'b0, 1'b1, 4'd5, 16'h0, rd, up, cw);
        check("R3 odd read", rd, 16'hFFFF);
        xfer(1'b1, 1'b1, 4'd0, 16'h0000, rd, up, cw);
        check("R3 wide mode write ignored", mode_o, 16'hFFA8);
        xfer(1'b0, 1'b1, 4'd2, 16'h0, rd, up, cw);
        check("R3 wide status read", rd, 16'hFFFF);
        xfer(1'b0, 1'b1, 4'd9, 16'h0, rd, up, cw);
        check("R3 odd count read", rd, 16'hFFFF);
    endtask

    task automatic t_unmapped;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b0, 1'b0, 4'd12, 16'h0, rd, up, cw);
        check("R4 read 12", rd, 16'hFFFF);
        xfer(1'b0, 1'b1, 4'd14, 16'h0, rd, up, cw);
        check("R4 read 14", rd, 16'hFFFF);
        xfer(1'b1, 1'b0, 4'd13, 16'h0000, rd, up, cw);
        check("R4 write cmpa", cmpa_o, 16'hBEEF);
        check("R4 write mode", mode_o, 16'hFFA8);
        check("R4 write stat", stat_o, 16'h0010);
        check("R4 write clk", clksel_o, 16'h1234);
        check("R4 write strobes", {12'd0, up, cw}, 16'h0000);
    endtask

    task automatic t_stat;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b0, 4'd3, 16'h00FF, rd, up, cw);
        check("R11 stat raw", stat_o, 16'h00FF);
        xfer(1'b0, 1'b0, 4'd3, 16'h0, rd, up, cw);
        check("R7 ch1 ones", rd, 16'h00DF);
        xfer(1'b1, 1'b0, 4'd2, 16'h00FF, rd, up, cw);
        check("R10 stat no strobe", {14'd0, up}, 16'h0000);
        xfer(1'b0, 1'b0, 4'd2, 16'h0, rd, up, cw);
        check("R7 ch0 full", rd, 16'h00FF);
        xfer(1'b1, 1'b0, 4'd3, 16'h0000, rd, up, cw);
        xfer(1'b0, 1'b0, 4'd3, 16'h0, rd, up, cw);
        check("R7 ch1 zeros", rd, 16'h0010);
    endtask

    task automatic t_count;
        logic [15:0] rd; logic [1:0] up, cw;
        cnt_i = 16'hA55A;
        xfer(1'b0, 1'b0, 4'd9, 16'h0, rd, up, cw);
        check("R9 ch1 count", rd, 16'h005A);
        xfer(1'b0, 1'b1, 4'd8, 16'h0, rd, up, cw);
        check("R9 wide count", rd, 16'hA55A);
        xfer(1'b1, 1'b0, 4'd8, 16'h0077, rd, up, cw);
        check("R9 ch0 write strobe", {14'd0, cw}, 16'h0001);
        check("R9 ch0 write data", {8'd0, cnt_wdata_o[15:8]}, 16'h0077);
        check("R10 count strobe", {14'd0, up}, 16'h0001);
        xfer(1'b1, 1'b1, 4'd8, 16'h1122, rd, up, cw);
        check("R9 wide write strobe", {14'd0, cw}, 16'h0003);
        check("R9 wide write data", cnt_wdata_o, 16'h1122);
        @(negedge clk);
        check("R9 strobe one cycle", {14'd0, cnt_we_o}, 16'h0000);
        check("R10 strobe one cycle", {14'd0, upd_o}, 16'h0000);
    endtask

    task automatic t_strobe;
        logic [15:0] rd; logic [1:0] up, cw;
        xfer(1'b1, 1'b0, 4'd7, 16'h0042, rd, up, cw);
        check("R10 cmpb ch1 strobe", {14'd0, up}, 16'h0002);
        check("R11 cmpb out", cmpb_o, 16'hFF42);
        @(negedge clk);
        check("R10 cmpb strobe drops", {14'd0, upd_o}, 16'h0000);
    endtask

    initial begin
        rst = 1'b1; req_i = 1'b0; we_i = 1'b0; wide_i = 1'b0;
        addr_i = '0; wdata_i = '0; cnt_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mode();
        t_clk();
        t_pack();
        t_illegal();
        t_unmapped();
        t_stat();
        t_count();
        t_strobe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule